// File: doc/BRIEF.md
# Parsimony Site Processing Unit

This unit evaluates one step of a parsimony tree traversal for a pair of alignment sites. It holds two banks of dual-port storage: a leaf bank holding the sequence data of the tree's tips, and an ancestral bank holding the state sets computed for inner nodes. Each storage word carries two sites. Each site is a 4-bit one-hot set of possible nucleotides.

On each command the unit reads the two child words named by the shared addresses. A two-bit case code picks which storage ports feed the q and r operands. For each site the unit forms the parent set and a mutation flag. When storing is requested, the parent word is written back. A result whose children both come from ancestral storage goes into a reserved area of leaf storage. This keeps every bank to two ports per cycle.

A command may also only score a node: flags and parent are reported, nothing is stored. Before any traversal, sequence data enters leaf storage through a dedicated load bus. Score summation and address generation live outside the unit.

Top module: `parsimony_site_unit`

## Requirements
- R1: A word holds site 0 in bits [7:4] and site 1 in bits [3:0]. Nucleotides are one-hot: A=1000, C=0100, G=0010, T=0001. `res_mut[0]` belongs to site 0 and `res_mut[1]` to site 1.
- R2: For a site whose two child sets share a bit (nonzero AND), the parent set is the AND and the site's mutation flag is 0.
- R3: For a site whose child sets are disjoint (zero AND), the parent set is the OR and the site's mutation flag is 1.
- R4: The two sites of a word are evaluated independently. One may mutate while the other does not.
- R5: `cmd_case` selects the operand sources:
  - 0 (tip-tip): q from leaf storage at `q_addr`, r from leaf storage at `r_addr`.
  - 1 (tip-inner): q from leaf at `q_addr`, r from ancestral at `r_addr`.
  - 2 (inner-inner): q from ancestral at `q_addr`, r from ancestral at `r_addr`.
  - 3 (inner-tip): q from ancestral at `q_addr`, r from leaf at `r_addr`.
- R6: A storing command (`cmd_store`=1) with case 0, 1 or 3 writes the parent word into ancestral storage at `p_addr`. Leaf storage is left alone.
- R7: A storing command with case 2 writes the parent word into leaf storage at `p_addr`, which is the reserved extra region. Ancestral storage is left alone.
- R8: A scoring-only command (`cmd_store`=0) reports flags and parent but changes neither bank.
- R9: `ld_en` writes `ld_data` into leaf storage at `ld_addr`. If it lands in the same cycle as an extra-region write, the load wins.
- R10: Timing after reset:
  - After reset, `res_valid`, `res_mut` and `res_vec` are 0.
  - A command sampled at clock edge k is reported at edge k+2, as a single-cycle `res_valid` pulse.
  - A command's stored result is visible to a command sampled at edge k+2 or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline registers |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_store | input | 1 | 1 = store parent, 0 = score only |
| cmd_case | input | 2 | Operand source case (R5) |
| q_addr | input | ADDR_W | Address of child q |
| r_addr | input | ADDR_W | Address of child r |
| p_addr | input | ADDR_W | Address for the parent word |
| ld_en | input | 1 | Load strobe for leaf storage |
| ld_addr | input | ADDR_W | Load address |
| ld_data | input | SITES*SYM_W | Load data word |
| res_valid | output | 1 | Result present |
| res_mut | output | SITES | Per-site mutation flags |
| res_vec | output | SITES*SYM_W | Parent word |

## Verification
The hardest situation to reach is a load and a deferred extra-region write colliding on the shared leaf port in the same cycle. The stimulus issues a storing inner-inner command and raises the load strobe for the same address exactly one cycle later. Afterwards a tip-tip readback against an all-ones word shows which value survived. Stores and score-only commands are likewise observed only through later readbacks: a word that must be unchanged is reported back through an AND with a word of all ones.

// File: rtl/parsimony_site_unit.sv
module parsimony_site_unit #(
  parameter int ADDR_W = 11,
  parameter int SITES  = 2,
  parameter int SYM_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic                     cmd_store,
  input  logic [1:0]               cmd_case,
  input  logic [ADDR_W-1:0]        q_addr,
  input  logic [ADDR_W-1:0]        r_addr,
  input  logic [ADDR_W-1:0]        p_addr,
  input  logic                     ld_en,
  input  logic [ADDR_W-1:0]        ld_addr,
  input  logic [SITES*SYM_W-1:0]   ld_data,
  output logic                     res_valid,
  output logic [SITES-1:0]         res_mut,
  output logic [SITES*SYM_W-1:0]   res_vec
);
  localparam int WORD_W = SITES * SYM_W;
  localparam int DEPTH  = 1 << ADDR_W;

  localparam logic [1:0] C_TT = 2'd0;
  localparam logic [1:0] C_TI = 2'd1;
  localparam logic [1:0] C_II = 2'd2;
  localparam logic [1:0] C_IT = 2'd3;

  logic [WORD_W-1:0] tip_mem   [DEPTH];
  logic [WORD_W-1:0] inner_mem [DEPTH];

  logic [WORD_W-1:0] tipa_q, tipb_q, inna_q, innb_q;
  logic [ADDR_W-1:0] tipa_addr, inna_addr;

  logic              s1_valid, s1_store;
  logic [1:0]        s1_case;
  logic [ADDR_W-1:0] s1_p;

  logic [WORD_W-1:0] opq, opr, parent;
  logic [SITES-1:0]  mut;

  logic              tip_we, inner_we;
  logic [ADDR_W-1:0] tip_wa;
  logic [WORD_W-1:0] tip_wd;

  assign tipa_addr = (cmd_case == C_IT) ? r_addr : q_addr;
  assign inna_addr = (cmd_case == C_TI) ? r_addr : q_addr;

  always_ff @(posedge clk) begin
    tipa_q <= tip_mem[tipa_addr];
    tipb_q <= tip_mem[r_addr];
    inna_q <= inner_mem[inna_addr];
    innb_q <= inner_mem[r_addr];
    if (tip_we)   tip_mem[tip_wa]  <= tip_wd;
    if (inner_we) inner_mem[s1_p]  <= parent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_store <= 1'b0;
      s1_case  <= C_TT;
      s1_p     <= '0;
    end else begin
      s1_valid <= cmd_valid;
      s1_store <= cmd_store;
      s1_case  <= cmd_case;
      s1_p     <= p_addr;
    end
  end

  always_comb begin
    case (s1_case)
      C_TT, C_TI: opq = tipa_q;
      default:    opq = inna_q;
    endcase
    case (s1_case)
      C_TT:    opr = tipb_q;
      C_TI:    opr = inna_q;
      C_II:    opr = innb_q;
      default: opr = tipa_q;
    endcase
  end

  for (genvar s = 0; s < SITES; s++) begin : g_site
    localparam int HI = WORD_W - 1 - s * SYM_W;
    logic [SYM_W-1:0] both, any;
    assign both = opq[HI -: SYM_W] & opr[HI -: SYM_W];
    assign any  = opq[HI -: SYM_W] | opr[HI -: SYM_W];
    assign mut[s] = (both == '0);
    assign parent[HI -: SYM_W] = mut[s] ? any : both;

    p_keep_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_mut[s]) |-> (res_vec[HI -: SYM_W] != '0));
  end

  wire nv_write = s1_valid && s1_store;
  assign inner_we = nv_write && (s1_case != C_II);
  assign tip_we   = ld_en || (nv_write && (s1_case == C_II));
  assign tip_wa   = ld_en ? ld_addr : s1_p;
  assign tip_wd   = ld_en ? ld_data : parent;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_mut   <= '0;
      res_vec   <= '0;
    end else begin
      res_valid <= s1_valid;
      if (s1_valid) begin
        res_mut <= mut;
        res_vec <= parent;
      end
    end
  end

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ##2 res_valid);
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> ##2 !res_valid);
  p_nv_inner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_store && s1_case != C_II) |=> (inner_mem[$past(s1_p)] === $past(parent)));
  p_nv_extra_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_store && s1_case == C_II && !ld_en) |=> (tip_mem[$past(s1_p)] === $past(parent)));
  p_ev_inner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_store) |=> (inner_mem[$past(s1_p)] === $past(inner_mem[s1_p])));
  p_ev_tip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_store && !ld_en) |=> (tip_mem[$past(s1_p)] === $past(tip_mem[s1_p])));
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (tip_mem[$past(ld_addr)] === $past(ld_data)));
endmodule

// File: tb/tb_parsimony_site_unit.sv
module tb_parsimony_site_unit;
  localparam int AW = 11;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_store = 0, ld_en = 0;
  logic [1:0] cmd_case = 0;
  logic [AW-1:0] q_addr = 0, r_addr = 0, p_addr = 0, ld_addr = 0;
  logic [7:0] ld_data = 0;
  logic res_valid;
  logic [1:0] res_mut;
  logic [7:0] res_vec;

  int checks = 0, fails = 0;
  logic [9:0] exp_q[$];
  string tag_q[$];
  logic [7:0] tip_m [int];
  logic [7:0] inn_m [int];
  localparam int ONES = 2047;

  always #2 clk = ~clk;

  parsimony_site_unit dut (.*);

  function automatic logic [9:0] evalw(input logic [7:0] q, input logic [7:0] r);
    logic [3:0] a0, a1, v0, v1; logic m0, m1;
    a0 = q[7:4] & r[7:4]; a1 = q[3:0] & r[3:0];
    m0 = (a0 == 0); m1 = (a1 == 0);
    v0 = m0 ? (q[7:4] | r[7:4]) : a0;
    v1 = m1 ? (q[3:0] | r[3:0]) : a1;
    return {m1, m0, v0, v1};
  endfunction

  task automatic load(input int a, input logic [7:0] d);
    @(negedge clk); ld_en = 1; ld_addr = AW'(a); ld_data = d;
    @(negedge clk); ld_en = 0;
    tip_m[a] = d;
  endtask

  task automatic cmd(input logic [1:0] c, input logic st, input int q, input int r, input int p, input string tag);
    logic [7:0] qv, rv; logic [9:0] e;
    qv = (c == 0 || c == 1) ? tip_m[q] : inn_m[q];
    rv = (c == 0 || c == 3) ? tip_m[r] : inn_m[r];
    e = evalw(qv, rv);
    exp_q.push_back(e); tag_q.push_back(tag);
    if (st) begin
      if (c == 2) tip_m[p] = e[7:0]; else inn_m[p] = e[7:0];
    end
    @(negedge clk);
    cmd_valid = 1; cmd_store = st; cmd_case = c;
    q_addr = AW'(q); r_addr = AW'(r); p_addr = AW'(p);
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic read_tip(input int a, input string tag);
    cmd(2'd0, 1'b0, a, ONES, 0, tag);
  endtask
  task automatic read_inn(input int a, input string tag);
    cmd(2'd1, 1'b0, ONES, a, 0, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected result: actual %h/%h expected none", res_mut, res_vec);
      end else begin
        logic [9:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if ({res_mut, res_vec} !== e) begin
          fails++;
          $display("FAIL %s: actual mut=%b vec=%h expected mut=%b vec=%h", t, res_mut, res_vec, e[9:8], e[7:0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (res_valid !== 0 || res_mut !== 0 || res_vec !== 0) begin
      fails++;
      $display("FAIL R10 reset: actual %b/%b/%h expected 0/00/00", res_valid, res_mut, res_vec);
    end
    rst_n = 1;
    load(ONES, 8'hFF);
    load(0, 8'h84);   // A,C
    load(1, 8'h82);   // A,G
    load(3, 8'h11);   // T,T
    load(4, 8'h28);   // G,A
    cmd(2'd0, 1, 0, 1, 5, "R2 R3 R4 tip-tip");
    read_inn(5, "R6 inner store");
    cmd(2'd1, 1, 3, 5, 6, "R3 R5 tip-inner");
    read_inn(6, "R6 tip-inner store");
    cmd(2'd0, 1, ONES, ONES, 100, "R2 fill inner 100");
    load(100, 8'h44);
    cmd(2'd2, 1, 5, 6, 100, "R2 R5 inner-inner");
    read_tip(100, "R7 extra region");
    read_inn(100, "R7 inner untouched");
    cmd(2'd3, 1, 6, 4, 7, "R3 R5 inner-tip");
    read_inn(7, "R6 inner-tip store");
    cmd(2'd0, 0, 0, 1, 6, "R8 score only");
    read_inn(6, "R8 inner unchanged");
    cmd(2'd2, 0, 5, 6, 1, "R8 score only inner-inner");
    read_tip(1, "R8 tip unchanged");
    // R9: extra write and load collide on the leaf port
    begin
      logic [9:0] e;
      e = evalw(inn_m[5], inn_m[7]);
      exp_q.push_back(e); tag_q.push_back("R9 collision cmd");
      @(negedge clk);
      cmd_valid = 1; cmd_store = 1; cmd_case = 2'd2;
      q_addr = 5; r_addr = 7; p_addr = 300;
      @(negedge clk); cmd_valid = 0; ld_en = 1; ld_addr = 300; ld_data = 8'h21;
      @(negedge clk); ld_en = 0;
      tip_m[300] = 8'h21;
    end
    read_tip(300, "R9 load wins");
    for (int i = 0; i < 16; i++) begin
      load(200 + i, {4'b1000 >> (i % 4), 4'b0001 << ((i / 4) % 4)});
    end
    for (int i = 0; i < 15; i++) begin
      cmd(2'd0, 0, 200 + i, 201 + i, 0, "R1 R4 pattern sweep");
    end
    repeat (6) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10 missing results: actual %0d pending expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule